// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running calendar (month, date, hours, minutes and seconds, each supplied as a BCD byte by an external time counter) and compares it with five host-written alarm bytes. The comparison runs once on every seconds tick. When every field agrees, a sticky alarm flag is set in a shared status byte. That status byte also reports a watchdog flag and a battery-low flag, both supplied from outside. If the alarm is enabled, the block drives an active-low interrupt that models an open-drain line.

Each alarm byte carries a don't-care bit in its top position. A masked field always counts as matching, so the host can build repeating alarms: once a minute, once an hour, once a day, or once every second when all fields are masked. The host clears the flag, and releases the interrupt, by reading the status byte.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, all five alarm bytes read 00h, the alarm flag is clear, irqN is high and rdData is 00h.
- R2: The alarm bytes sit at fixed addresses: 6h month, 5h date, 4h hours, 3h minutes, 2h seconds. A write stores the full byte. A read with rdEn presents the stored byte on rdData one cycle later.
- R3: On a cycle with secTick high where all five fields match, status bit 6 (alarm flag) is set from the next cycle on.
- R4: The flag is not set by a tick on which any unmasked field differs, and it is not set by a matching calendar without a tick.
- R5: Bit 7 of an alarm byte masks that field, which then always matches. With all five masked, every tick sets the flag.
- R6: Only the meaningful bits of each field are compared: bits 4:0 for month, bits 5:0 for date and hours, and bits 6:0 for minutes and seconds. The other bits, on either side, are ignored.
- R7: Bit 6 of the month alarm byte enables the interrupt. irqN is low exactly while the flag is set and that enable is 1. The flag is set whether or not the enable is 1.
- R8: A read of address 0h returns the status byte as it was before the read, and clears the flag from the next cycle, which raises irqN.
- R9: If a matching tick falls on the same cycle as a status read, the flag is set again and stays set.
- R10: Status bit 7 reports wdFlag and status bit 4 reports batLow. The other status bits read 0. Reads of address 1h and of 7h to Fh return 00h.
- R11: Once set, the flag holds across later non-matching ticks until a status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Host register address |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write data |
| rdEn | input | 1 | Host read strobe |
| rdData | output | 8 | Read data, valid the cycle after rdEn |
| secTick | input | 1 | One-cycle seconds tick from the time counter |
| curMonth | input | 8 | Current month, BCD |
| curDate | input | 8 | Current date, BCD |
| curHours | input | 8 | Current hours, BCD |
| curMinutes | input | 8 | Current minutes, BCD |
| curSeconds | input | 8 | Current seconds, BCD |
| wdFlag | input | 1 | Watchdog flag shown in the status byte |
| batLow | input | 1 | Battery-low flag shown in the status byte |
| irqN | output | 1 | Active-low alarm interrupt |

## Verification
Read data appears on rdData one clock edge after the cycle in which rdEn is sampled. A matching tick becomes visible in the flag and on irqN one edge after the tick cycle, and a status read clears them one edge after the read cycle. The bench drives every stimulus at the falling edge and holds it for exactly one rising edge. A monitor pops the expected read byte at the falling edge that follows the capturing rising edge. irqN is sampled at the falling edge right after the tick or read cycle ends, which falls between the edge that updates it and the next one.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int FIELD_COUNT = 5;
  localparam int FIELD_IDX_W = $clog2(FIELD_COUNT);

  // bit positions inside alarm bytes and status byte
  localparam int MASK_BIT     = 7;
  localparam int ENABLE_BIT   = 6;
  localparam int ST_WD_BIT    = 7;
  localparam int ST_ALARM_BIT = 6;
  localparam int ST_BAT_BIT   = 4;

  // field index 0 = seconds (lowest address) .. 4 = month
  localparam int MONTH_IDX = FIELD_COUNT - 1;

  typedef struct packed {
    logic                   loadAlarm;
    logic                   readAlarm;
    logic                   readStatus;
    logic [FIELD_IDX_W-1:0] fieldIdx;
  } ctrlStrobes_t;

  typedef logic [FIELD_COUNT-1:0][DATA_W-1:0] calVec_t;

  // significant compare bits of each calendar field
  function automatic logic [DATA_W-1:0] fieldBits(input int idx);
    case (idx)
      0, 1:    fieldBits = DATA_W'(8'h7F);
      2, 3:    fieldBits = DATA_W'(8'h3F);
      default: fieldBits = DATA_W'(8'h1F);
    endcase
  endfunction

endpackage

// File: rtl/alarm_match_datapath.sv
module alarm_match_datapath
  import alarm_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  calVec_t           curTime,
  input  logic              alarmFlag,
  input  logic              wdFlag,
  input  logic              batLow,
  output logic              allHit,
  output logic              alarmEnable,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0]      alarmRegs [FIELD_COUNT];
  logic [FIELD_COUNT-1:0] fieldHit;
  logic [DATA_W-1:0]      statusByte;

  // alarm byte storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FIELD_COUNT; i++) alarmRegs[i] <= '0;
    end else if (strobes.loadAlarm) begin
      alarmRegs[strobes.fieldIdx] <= wrData;
    end
  end

  // per-field comparator with don't-care mask
  for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_field
    localparam logic [DATA_W-1:0] FIELD_BITS = fieldBits(f);
    logic maskedOut;
    logic sameValue;
    assign maskedOut   = alarmRegs[f][MASK_BIT];
    assign sameValue   = (alarmRegs[f] & FIELD_BITS) == (curTime[f] & FIELD_BITS);
    assign fieldHit[f] = maskedOut | sameValue;
  end

  assign allHit      = &fieldHit;
  assign alarmEnable = alarmRegs[MONTH_IDX][ENABLE_BIT];

  always_comb begin
    statusByte               = '0;
    statusByte[ST_WD_BIT]    = wdFlag;
    statusByte[ST_ALARM_BIT] = alarmFlag;
    statusByte[ST_BAT_BIT]   = batLow;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.readStatus) begin
      rdData <= statusByte;
    end else if (strobes.readAlarm) begin
      rdData <= alarmRegs[strobes.fieldIdx];
    end else begin
      rdData <= '0;
    end
  end

  AST_ALARM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAlarm |=> alarmRegs[$past(strobes.fieldIdx)] == $past(wrData)); // R2

  AST_STATUS_READ_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readStatus |=> rdData[ST_ALARM_BIT] == $past(alarmFlag)); // R8

endmodule

// File: rtl/alarm_match_control.sv
module alarm_match_control
  import alarm_match_pkg::*;
#(
  parameter int ALARM_BASE  = 2,
  parameter int STATUS_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              secTick,
  input  logic              allHit,
  output ctrlStrobes_t      strobes,
  output logic              alarmFlag
);

  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(ALARM_BASE);
  localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(ALARM_BASE + FIELD_COUNT - 1);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  logic inAlarmRange;
  logic setFlag;
  logic clrFlag;
  logic [ADDR_W-1:0] offset;

  assign inAlarmRange = (regAddr >= BASE_A) && (regAddr <= LAST_A);
  assign offset       = regAddr - BASE_A;

  always_comb begin
    strobes            = '0;
    strobes.fieldIdx   = offset[FIELD_IDX_W-1:0];
    strobes.loadAlarm  = wrEn && inAlarmRange;
    strobes.readAlarm  = rdEn && inAlarmRange;
    strobes.readStatus = rdEn && (regAddr == STATUS_A);
  end

  assign setFlag = secTick && allHit;
  assign clrFlag = strobes.readStatus;

  // sticky flag: a set on the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN)        alarmFlag <= 1'b0;
    else if (setFlag) alarmFlag <= 1'b1;
    else if (clrFlag) alarmFlag <= 1'b0;
  end

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && allHit) |=> alarmFlag); // R3

  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !alarmFlag) |=> !alarmFlag); // R4

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == STATUS_A && !(secTick && allHit)) |=> !alarmFlag); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(rdEn && regAddr == STATUS_A)) |=> alarmFlag); // R11

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
#(
  parameter int ALARM_BASE  = 2,
  parameter int STATUS_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              secTick,
  input  logic [DATA_W-1:0] curMonth,
  input  logic [DATA_W-1:0] curDate,
  input  logic [DATA_W-1:0] curHours,
  input  logic [DATA_W-1:0] curMinutes,
  input  logic [DATA_W-1:0] curSeconds,
  input  logic              wdFlag,
  input  logic              batLow,
  output logic              irqN
);

  ctrlStrobes_t strobes;
  calVec_t      curTime;
  logic         allHit;
  logic         alarmEnable;
  logic         alarmFlag;

  assign curTime = {curMonth, curDate, curHours, curMinutes, curSeconds};

  alarm_match_control #(
    .ALARM_BASE  (ALARM_BASE),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .secTick   (secTick),
    .allHit    (allHit),
    .strobes   (strobes),
    .alarmFlag (alarmFlag)
  );

  alarm_match_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .curTime     (curTime),
    .alarmFlag   (alarmFlag),
    .wdFlag      (wdFlag),
    .batLow      (batLow),
    .allHit      (allHit),
    .alarmEnable (alarmEnable),
    .rdData      (rdData)
  );

  assign irqN = ~(alarmFlag & alarmEnable);

endmodule

// File: tb/tb_alarm_match_top.sv
module tb_alarm_match_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] regAddr;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic       secTick;
  logic [7:0] curMonth, curDate, curHours, curMinutes, curSeconds;
  logic       wdFlag, batLow;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rdItem_t;

  rdItem_t expQ[$];
  logic    rdFired;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_top dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .secTick(secTick),
    .curMonth(curMonth), .curDate(curDate), .curHours(curHours),
    .curMinutes(curMinutes), .curSeconds(curSeconds),
    .wdFlag(wdFlag), .batLow(batLow), .irqN(irqN)
  );

  always @(posedge clk) rdFired <= rdEn;

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rdFired === 1'b1) begin
      rdItem_t it;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected read, actual %02h expected none", "R2", rdData);
      end else begin
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          errors++;
          $display("FAIL %s: rdData actual %02h expected %02h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [7:0] e, input string tag);
    rdItem_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doTick();
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic readWithTick(input logic [7:0] e, input string tag);
    rdItem_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    regAddr = 4'h0; rdEn = 1'b1; secTick = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; secTick = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    checks++;
    if (irqN !== e) begin
      errors++;
      $display("FAIL %s: irqN actual %b expected %b", tag, irqN, e);
    end
  endtask

  task automatic setTime(input logic [7:0] mo, dt, hr, mi, se);
    curMonth = mo; curDate = dt; curHours = hr; curMinutes = mi; curSeconds = se;
  endtask

  task automatic writeAlarm(input logic [7:0] mo, dt, hr, mi, se);
    doWrite(4'h6, mo); doWrite(4'h5, dt); doWrite(4'h4, hr);
    doWrite(4'h3, mi); doWrite(4'h2, se);
  endtask

  task automatic flush();
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; regAddr = '0; wrEn = 0; wrData = '0; rdEn = 0; secTick = 0;
    wdFlag = 0; batLow = 0;
    setTime(8'h07, 8'h15, 8'h09, 8'h30, 8'h45);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkIrq(1'b1, "R1");
    doRead(4'h0, 8'h00, "R1");
    for (int a = 2; a <= 6; a++) doRead(4'(a), 8'h00, "R1");

    // R2 write and read back at fixed addresses
    writeAlarm(8'h07, 8'h15, 8'h09, 8'h30, 8'h45);
    doRead(4'h6, 8'h07, "R2"); doRead(4'h5, 8'h15, "R2");
    doRead(4'h4, 8'h09, "R2"); doRead(4'h3, 8'h30, "R2");
    doRead(4'h2, 8'h45, "R2");

    // R4 mismatch on tick, and match without tick
    curSeconds = 8'h44; doTick();
    doRead(4'h0, 8'h00, "R4");
    curSeconds = 8'h45; repeat (4) flush();
    doRead(4'h0, 8'h00, "R4");

    // R3 / R7 match sets flag, irq stays high with enable off
    doTick();
    checkIrq(1'b1, "R7");
    doRead(4'h0, 8'h40, "R3");
    doRead(4'h0, 8'h00, "R8");

    // R7 enable on drives irq low
    doWrite(4'h6, 8'h47);
    doTick();
    checkIrq(1'b0, "R7");
    // R11 sticky across non-matching ticks
    curSeconds = 8'h46; doTick(); doTick();
    checkIrq(1'b0, "R11");
    // R8 read returns pre-clear value and releases irq
    doRead(4'h0, 8'h40, "R8");
    checkIrq(1'b1, "R8");
    doRead(4'h0, 8'h00, "R8");

    // R9 match on same cycle as status read keeps flag
    curSeconds = 8'h45; doTick();
    checkIrq(1'b0, "R9");
    readWithTick(8'h40, "R9");
    checkIrq(1'b0, "R9");
    doRead(4'h0, 8'h40, "R9");
    checkIrq(1'b1, "R8");

    // R5 all masked: every tick sets flag
    setTime(8'h03, 8'h28, 8'h17, 8'h02, 8'h11);
    writeAlarm(8'hC0, 8'h80, 8'h80, 8'h80, 8'h80);
    doTick();
    checkIrq(1'b0, "R5");
    doRead(4'h0, 8'h40, "R5");
    curSeconds = 8'h12; doTick();
    doRead(4'h0, 8'h40, "R5");
    // R5 only seconds masked
    writeAlarm(8'h03, 8'h28, 8'h17, 8'h02, 8'h80);
    curSeconds = 8'h59; doTick();
    doRead(4'h0, 8'h40, "R5");
    // R4 one unmasked field differs
    curMinutes = 8'h03; doTick();
    doRead(4'h0, 8'h00, "R4");

    // R6 unused bits ignored on both sides
    setTime(8'hE3, 8'h28, 8'h17, 8'h02, 8'h11);
    writeAlarm(8'h03, 8'h68, 8'h57, 8'h02, 8'h11);
    doTick();
    doRead(4'h0, 8'h40, "R6");
    // R6 meaningful bit differs in hours
    curHours = 8'h16; doTick();
    doRead(4'h0, 8'h00, "R6");

    // R10 status side flags and unmapped addresses
    wdFlag = 1; batLow = 1;
    doRead(4'h0, 8'h90, "R10");
    wdFlag = 0;
    doRead(4'h0, 8'h10, "R10");
    batLow = 0;
    doRead(4'h1, 8'h00, "R10");
    doRead(4'h7, 8'h00, "R10");
    doRead(4'hF, 8'h00, "R10");

    flush(); flush();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule